// File: doc/BRIEF.md
# Programmable Almost-Full Flag Generator

This block drives the active-low almost-full flag of a dual-clock FIFO. It keeps the write pointer in the write clock domain. A read-side counter, clocked by the read clock, tracks accepted reads and publishes its pointer as a Gray code. A chain of synchronizer stages carries that code into the write domain. The block compares the fill level seen from the write side with a threshold. The threshold equals the effective depth minus the offset `offset_m`.

Three mode pins are captured only while master reset is held. `sync_sel` picks the timing mode. With registered timing, the flag changes only on rising write-clock edges. With the other timing, the flag follows the live pointers directly. `narrow_sel` doubles the base depth. `fwft_sel` adds one word to the depth. Reads must not be issued while the FIFO is empty. The offset is changed only while reset is held.

The registered flag comes from a two-state machine. In state `PF_OPEN` the flag is high. The machine moves to `PF_ALMOST` when the next fill level reaches the threshold. In `PF_ALMOST` the flag is low. The machine returns to `PF_OPEN` when the next fill level drops below the threshold. Master reset puts the machine in `PF_OPEN`.

Top module: `paf_flag_gen`

## Requirements
- R1: While `mrst_n` is low the flag `paf_n` is high.
- R2: In registered timing, `paf_n` goes low right after the write-clock edge that accepts the write bringing the level to the threshold (depth minus `offset_m`).
- R3: While the level is at or above the threshold, `paf_n` stays low. It is high whenever the level is below the threshold.
- R4: In registered timing, a read that brings the level below the threshold releases the flag. If the read edge leads the write edge by at least the synchronizer margin, the release comes after the second rising write-clock edge following the read edge. Otherwise it comes one write-clock edge later.
- R5: With `narrow_sel` high at reset, the depth is twice `BASE_DEPTH`.
- R6: With `fwft_sel` high at reset, the depth grows by one word.
- R7: The mode pins are sampled only during reset. Changes after reset have no effect on threshold or timing.
- R8: With `sync_sel` low at reset, the flag follows the live pointers. It rises right after the read edge, without waiting for a write-clock edge.
- R9: A write issued while the write-side level equals the depth is ignored. A later single read therefore takes the level below the depth.
- R10: An offset at or above the depth sets the threshold to zero. The flag is then low from the first write-clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| wen | input | 1 | Write request, sampled on `wclk` |
| ren | input | 1 | Read event, sampled on `rclk` |
| sync_sel | input | 1 | High selects registered flag timing (captured in reset) |
| fwft_sel | input | 1 | High adds one word of depth (captured in reset) |
| narrow_sel | input | 1 | High doubles the depth (captured in reset) |
| offset_m | input | OW | Almost-full offset m |
| paf_n | output | 1 | Almost-full flag, active low |

## Verification
A corrupted write pointer or synchronized read pointer shows on `paf_n` at the next threshold crossing. The flag falls one write too early or too late, or it fails to rise after the read that should release it. A wrong synchronizer depth shifts the registered release by whole write-clock cycles, and the first read across the threshold exposes it. A mode latch that tracks its pins after reset changes the threshold at the first fill that follows.

// File: rtl/paf_pkg.sv
package paf_pkg;

    typedef enum logic [0:0] {
        PF_OPEN   = 1'b0,
        PF_ALMOST = 1'b1
    } paf_state_e;

    typedef struct packed {
        logic sync_timing;
        logic fall_through;
        logic narrow;
    } paf_cfg_t;

endpackage

// File: rtl/paf_cfg_latch.sv
module paf_cfg_latch
    import paf_pkg::*;
(
    input  logic     wclk,
    input  logic     mrst_n,
    input  logic     sync_sel,
    input  logic     fwft_sel,
    input  logic     narrow_sel,
    output paf_cfg_t cfg_q
);

    // Pins are captured on every write-clock edge while reset is held.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            cfg_q.sync_timing  <= sync_sel;
            cfg_q.fall_through <= fwft_sel;
            cfg_q.narrow       <= narrow_sel;
        end
    end

    assert_cfg_frozen_R7: assert property (
        @(posedge wclk) disable iff (!mrst_n) $stable(cfg_q)
    );

endmodule

// File: rtl/paf_rd_ptr.sv
module paf_rd_ptr #(
    parameter int PW = 7
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          ren,
    output logic [PW-1:0] rbin_q,
    output logic [PW-1:0] rgray_q
);

    logic [PW-1:0] rbin_d;

    always_comb rbin_d = rbin_q + PW'(ren);

    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
        end else begin
            rbin_q  <= rbin_d;
            rgray_q <= rbin_d ^ (rbin_d >> 1);
        end
    end

    // Pointer crossing is safe only if one bit moves per step (R4 timing).
    assert_gray_single_step_R4: assert property (
        @(posedge rclk) disable iff (!mrst_n)
            $countones(rgray_q ^ $past(rgray_q)) <= 1
    );

endmodule

// File: rtl/paf_gray_sync.sv
module paf_gray_sync #(
    parameter int PW     = 7,
    parameter int STAGES = 2
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_q,
    output logic [PW-1:0] bin_d
);

    logic [PW-1:0] chain [STAGES];

    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '0;
        end else begin
            chain[0] <= gray_in;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    // Gray to binary for the last stage and for the value about to enter it.
    for (genvar i = 0; i < PW; i++) begin : g_conv
        assign bin_q[i] = ^chain[STAGES-1][PW-1:i];
        assign bin_d[i] = ^chain[STAGES-2][PW-1:i];
    end

endmodule

// File: rtl/paf_wr_side.sv
module paf_wr_side
    import paf_pkg::*;
#(
    parameter int BASE_DEPTH = 16,
    parameter int PW         = 7,
    parameter int OW         = 6
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          wen,
    input  paf_cfg_t      cfg,
    input  logic [OW-1:0] offset_m,
    input  logic [PW-1:0] rsync_q,
    input  logic [PW-1:0] rsync_d,
    input  logic [PW-1:0] rbin_raw,
    output logic          paf_n
);

    localparam logic [PW-1:0] BASE_W = PW'(BASE_DEPTH);

    paf_state_e    state_q, state_d;
    logic [PW-1:0] wptr_q, wptr_d;
    logic [PW-1:0] depth_eff, offset_w, thr;
    logic [PW-1:0] level_q, level_d, level_raw;
    logic          wr_ok;

    always_comb begin
        depth_eff = (cfg.narrow ? (BASE_W << 1) : BASE_W) + PW'(cfg.fall_through);
        offset_w  = PW'(offset_m);
        thr       = (offset_w >= depth_eff) ? '0 : depth_eff - offset_w;
        level_q   = wptr_q - rsync_q;
        wr_ok     = wen && (level_q < depth_eff);
        wptr_d    = wptr_q + PW'(wr_ok);
        level_d   = wptr_d - rsync_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PF_OPEN:   if (level_d >= thr) state_d = PF_ALMOST;
            PF_ALMOST: if (level_d <  thr) state_d = PF_OPEN;
            default:   state_d = PF_OPEN;
        endcase
    end

    // State register and write pointer
    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            state_q <= PF_OPEN;
            wptr_q  <= '0;
        end else begin
            state_q <= state_d;
            wptr_q  <= wptr_d;
        end
    end

    // Output process
    always_comb begin
        level_raw = wptr_q - rbin_raw;
        if (!mrst_n)              paf_n = 1'b1;
        else if (cfg.sync_timing) paf_n = (state_q == PF_OPEN);
        else                      paf_n = (level_raw < thr);
    end

    assert_no_overflow_R9: assert property (
        @(posedge wclk) disable iff (!mrst_n) level_q <= depth_eff
    );

    assert_fall_needs_write_R2: assert property (
        @(posedge wclk) disable iff (!mrst_n)
            (state_q == PF_ALMOST && $past(state_q) == PF_OPEN)
                |-> ($past(wr_ok) || thr == '0)
    );

    assert_release_needs_read_R4: assert property (
        @(posedge wclk) disable iff (!mrst_n)
            (state_q == PF_OPEN && $past(state_q) == PF_ALMOST)
                |-> (rsync_q != $past(rsync_q))
    );

endmodule

// File: rtl/paf_flag_gen.sv
module paf_flag_gen
    import paf_pkg::*;
#(
    parameter int BASE_DEPTH  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int OW         = $clog2(2 * BASE_DEPTH + 2),
    localparam int PW         = OW + 1
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          wen,
    input  logic          ren,
    input  logic          sync_sel,
    input  logic          fwft_sel,
    input  logic          narrow_sel,
    input  logic [OW-1:0] offset_m,
    output logic          paf_n
);

    paf_cfg_t      cfg;
    logic [PW-1:0] rbin, rgray, rsync_q, rsync_d;

    paf_cfg_latch u_cfg (
        .wclk       (wclk),
        .mrst_n     (mrst_n),
        .sync_sel   (sync_sel),
        .fwft_sel   (fwft_sel),
        .narrow_sel (narrow_sel),
        .cfg_q      (cfg)
    );

    paf_rd_ptr #(.PW(PW)) u_rd (
        .rclk    (rclk),
        .mrst_n  (mrst_n),
        .ren     (ren),
        .rbin_q  (rbin),
        .rgray_q (rgray)
    );

    paf_gray_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_sync (
        .wclk    (wclk),
        .mrst_n  (mrst_n),
        .gray_in (rgray),
        .bin_q   (rsync_q),
        .bin_d   (rsync_d)
    );

    paf_wr_side #(.BASE_DEPTH(BASE_DEPTH), .PW(PW), .OW(OW)) u_wr (
        .wclk     (wclk),
        .mrst_n   (mrst_n),
        .wen      (wen),
        .cfg      (cfg),
        .offset_m (offset_m),
        .rsync_q  (rsync_q),
        .rsync_d  (rsync_d),
        .rbin_raw (rbin),
        .paf_n    (paf_n)
    );

endmodule

// File: tb/paf_flag_gen_bench.sv
module paf_flag_gen_bench;

    localparam int BASE = 16;
    localparam int OW   = $clog2(2 * BASE + 2);

    logic          wclk = 0, rclk = 0, mrst_n = 0;
    logic          wen = 0, ren = 0;
    logic          sync_sel = 1, fwft_sel = 0, narrow_sel = 0;
    logic [OW-1:0] offset_m = '0;
    logic          paf_n;

    int n_checks = 0, n_fail = 0;
    int lvl_w, stored, thr_m, d_m;
    bit rd_pending, m_sync, done = 0;

    paf_flag_gen #(.BASE_DEPTH(BASE)) u_paf_flag_gen (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .wen(wen), .ren(ren),
        .sync_sel(sync_sel), .fwft_sel(fwft_sel), .narrow_sel(narrow_sel),
        .offset_m(offset_m), .paf_n(paf_n)
    );

    // 100 MHz write clock rising at 5,15,..; read clock leads it by 3 ns
    always begin #5 wclk = 1; #5 wclk = 0; end
    always begin #2 rclk = 1; #5 rclk = 0; #3; end

    function automatic int f_depth(bit n, bit f);
        return (n ? 2 * BASE : BASE) + (f ? 1 : 0);
    endfunction

    function automatic int f_thr(int d, int off);
        return (off >= d) ? 0 : d - off;
    endfunction

    task automatic check(logic got, logic exp, string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: paf_n=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_reset(bit s, bit f, bit n, int off);
        @(negedge wclk);
        mrst_n = 0; wen = 0; ren = 0;
        sync_sel = s; fwft_sel = f; narrow_sel = n; offset_m = OW'(off);
        repeat (3) @(negedge wclk);
        check(paf_n, 1'b1, "R1");
        mrst_n = 1;
        m_sync = s; d_m = f_depth(n, f); thr_m = f_thr(d_m, off);
        lvl_w = 0; stored = 0; rd_pending = 0;
    endtask

    task automatic step(bit w, bit r, string tag);
        bit rd, wok, exp;
        @(negedge wclk);
        rd  = r && (stored > 0);
        wen = w; ren = rd;
        #9;
        wok = w && (lvl_w < d_m);
        lvl_w = lvl_w + int'(wok) - int'(rd_pending);
        rd_pending = rd;
        stored = stored + int'(wok) - int'(rd);
        exp = m_sync ? !(lvl_w >= thr_m) : !(stored >= thr_m);
        check(paf_n, exp, tag);
    endtask

    initial begin
        void'($urandom(32'd7));
        // R2/R3/R4: registered timing, D=16, m=4, threshold 12
        do_reset(1, 0, 0, 4);
        for (int i = 0; i < 12; i++) step(1, 0, "R2");
        for (int i = 0; i < 2; i++)  step(1, 0, "R3");
        for (int i = 0; i < 3; i++)  step(0, 1, "R4");
        for (int i = 0; i < 3; i++)  step(0, 0, "R4");
        // R9: m=0, overfill then one read
        do_reset(1, 0, 0, 0);
        for (int i = 0; i < 20; i++) step(1, 0, "R9");
        step(0, 1, "R9");
        for (int i = 0; i < 3; i++)  step(0, 0, "R9");
        // R5: narrow bus doubles depth
        do_reset(1, 0, 1, 3);
        for (int i = 0; i < 30; i++) step(1, 0, "R5");
        // R6: fall-through adds one word
        do_reset(1, 1, 0, 3);
        for (int i = 0; i < 15; i++) step(1, 0, "R6");
        // R7: pins changed after reset are ignored
        do_reset(1, 0, 0, 2);
        sync_sel = 0; fwft_sel = 1; narrow_sel = 1;
        for (int i = 0; i < 15; i++) step(1, 0, "R7");
        for (int i = 0; i < 2; i++)  step(0, 1, "R7");
        for (int i = 0; i < 3; i++)  step(0, 0, "R7");
        // R8: live timing releases at the read edge
        do_reset(0, 0, 0, 4);
        for (int i = 0; i < 13; i++) step(1, 0, "R8");
        for (int i = 0; i < 3; i++)  step(0, 1, "R8");
        // R10: offset at or above depth
        do_reset(1, 0, 0, 40);
        for (int i = 0; i < 3; i++)  step(0, 0, "R10");
        do_reset(0, 0, 0, 16);
        for (int i = 0; i < 3; i++)  step(0, 0, "R10");
        // Random traffic in both timings
        for (int pass = 0; pass < 4; pass++) begin
            do_reset(pass[0], pass[1], 0, int'($urandom % 8));
            for (int i = 0; i < 400; i++)
                step(($urandom % 100) < 60, ($urandom % 100) < 45, "R3");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule